// File: doc/BRIEF.md
# Interval Timers with Watchdog

This block keeps two 16-bit interval counters and one 16-bit watchdog counter, all paced by a slow external timing clock that runs asynchronously to the system clock. The slow clock is brought into the system domain through a synchronizer and edge detector. Each rising slow edge produces a one-cycle tick, and each falling slow edge produces another. Timer A counts every rising tick. Timer B counts once per ten rising ticks, through a prescaler that restarts whenever timer B is loaded. The watchdog counts falling ticks.

Each interval timer takes load, start, halt and reload-register-write commands. When a timer passes its maximum count it emits a one-cycle interrupt pulse. In extended mode, a timer that has been loaded since reset restarts from its reload register; in every other case it restarts from zero. A console-hold input freezes both interval timers. The watchdog cannot be disabled. On overflow it pulls an active-low timeout line low, and the line stays low until a go command restarts the watchdog from its own reload register. Command decode and interrupt handling are done elsewhere. Command inputs are single-cycle strobes in the system clock domain.

Top module: `tick_timer_cluster`

## Requirements
- R1: After reset, all three counts and all reload registers are zero, both interval timers are running, no interrupt pulse is present and `wd_timeout_n` is high.
- R2: While timer A is running and `console_hold` is low, `tma_count` increases by one for each rising edge of `slow_clk`.
- R3: Timer B advances once per ten rising edges of `slow_clk` counted while it runs unheld. A timer B load restarts this ten-edge division from the beginning.
- R4: A load strobe copies `wr_data` into that timer's count on the next clock edge, marks the timer as loaded, and takes precedence over a count step in the same cycle.
- R5: A halt strobe stops a timer and a start strobe resumes it. When both arrive in the same cycle, the timer is halted.
- R6: While `console_hold` is high, neither interval timer nor the timer B prescaler advances.
- R7: When a running timer steps from 0xFFFF, its interrupt output (`tma_irq` or `tmb_irq`) is high for exactly one clock cycle.
- R8: On overflow, the count becomes that timer's reload register if `ext_mode` is high and the timer has been loaded since reset. Otherwise the count becomes zero.
- R9: `wd_count` increases by one for each falling edge of `slow_clk` and never changes otherwise, except through a go strobe. Console hold and timer commands do not affect it.
- R10: When the watchdog steps from 0xFFFF, it wraps to zero and `wd_timeout_n` goes low. The line stays low until `wd_go`, which reloads `wd_count` from the watchdog reload register and raises `wd_timeout_n`. With a reload value of zero, the timeout comes on the 65536th falling edge.
- R11: A reload-register write (`tma_rr_wr`, `tmb_rr_wr`, `wd_rr_wr`) stores `wr_data` and leaves all counts unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_clk | input | 1 | Asynchronous slow timing clock |
| console_hold | input | 1 | Freezes both interval timers while high |
| ext_mode | input | 1 | Enables the conditional reload-on-overflow |
| wr_data | input | 16 | Data for load and reload-register writes |
| tma_load | input | 1 | Load timer A count |
| tma_start | input | 1 | Start timer A |
| tma_halt | input | 1 | Halt timer A |
| tma_rr_wr | input | 1 | Write timer A reload register |
| tmb_load | input | 1 | Load timer B count and clear prescaler |
| tmb_start | input | 1 | Start timer B |
| tmb_halt | input | 1 | Halt timer B |
| tmb_rr_wr | input | 1 | Write timer B reload register |
| wd_rr_wr | input | 1 | Write watchdog reload register |
| wd_go | input | 1 | Reload watchdog and clear timeout |
| tma_count | output | 16 | Timer A count |
| tmb_count | output | 16 | Timer B count |
| wd_count | output | 16 | Watchdog count |
| tma_irq | output | 1 | Timer A overflow pulse |
| tmb_irq | output | 1 | Timer B overflow pulse |
| wd_timeout_n | output | 1 | Watchdog timeout, active low |

## Verification
The assertions check, on every clock cycle, the following properties:
- load precedence;
- the freeze under console hold;
- the single-cycle width of the overflow pulses and that they follow a count of 0xFFFF;
- the overflow value when the reload condition fails;
- the stickiness of the timeout;
- that the watchdog moves only on a falling tick or a go strobe.

Some behaviour can only be shown by the bench's scenarios, because it spans many slow-clock edges. This covers the divide-by-ten ratio and its restart on load, the exact count sequences under mixed commands, and the reload values taken in extended mode. It also covers the full 65536-edge watchdog period, and the overflow of a timer that has never been loaded.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  typedef struct packed {
    logic load;
    logic start;
    logic halt;
    logic rr_wr;
  } tmr_cmd_t;
endpackage

// File: rtl/slow_clk_sync.sv
module slow_clk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_tick,
  output logic fall_tick
);
  logic [STAGES-1:0] sync_q, sync_d;
  logic              prev_q, prev_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], async_in};
    prev_d = sync_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign rise_tick = sync_q[STAGES-1] & ~prev_q;
  assign fall_tick = ~sync_q[STAGES-1] & prev_q;
endmodule

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
  parameter int DIV = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic step,
  output logic carry
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    if (clear) begin
      phase_d = '0;
    end else if (step) begin
      phase_d = (phase_q == LAST) ? '0 : phase_q + 1'b1;
    end
  end

  assign carry = step && !clear && (phase_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end
endmodule

// File: rtl/interval_counter.sv
module interval_counter
  import tick_timer_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         hold,
  input  logic         ext_mode,
  input  tmr_cmd_t     cmd,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] count,
  output logic         ovf_pulse,
  output logic         loaded,
  output logic         running
);
  localparam logic [W-1:0] CNT_MAX = '1;

  logic [W-1:0] cnt_q, cnt_d, rr_q, rr_d;
  logic         ld_q, ld_d, run_q, run_d, ovf_q, ovf_d;
  logic         step_en;

  assign step_en = tick && run_q && !hold;

  always_comb begin
    cnt_d = cnt_q;
    rr_d  = rr_q;
    ld_d  = ld_q;
    run_d = run_q;
    ovf_d = 1'b0;
    if (cmd.rr_wr) rr_d = wr_data;
    if (cmd.start) run_d = 1'b1;
    if (cmd.halt)  run_d = 1'b0;
    if (cmd.load) begin
      cnt_d = wr_data;
      ld_d  = 1'b1;
    end else if (step_en) begin
      if (cnt_q == CNT_MAX) begin
        ovf_d = 1'b1;
        cnt_d = (ext_mode && ld_q) ? rr_q : '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rr_q  <= '0;
      ld_q  <= 1'b0;
      run_q <= 1'b1;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      rr_q  <= rr_d;
      ld_q  <= ld_d;
      run_q <= run_d;
      ovf_q <= ovf_d;
    end
  end

  assign count     = cnt_q;
  assign ovf_pulse = ovf_q;
  assign loaded    = ld_q;
  assign running   = run_q;
endmodule

// File: rtl/watchdog_counter.sv
module watchdog_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         go,
  input  logic         rr_wr,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] count,
  output logic [W-1:0] reload_val,
  output logic         timeout_n
);
  localparam logic [W-1:0] CNT_MAX = '1;

  logic [W-1:0] cnt_q, cnt_d, rr_q, rr_d;
  logic         to_n_q, to_n_d;

  always_comb begin
    cnt_d  = cnt_q;
    rr_d   = rr_q;
    to_n_d = to_n_q;
    if (rr_wr) rr_d = wr_data;
    if (go) begin
      cnt_d  = rr_q;
      to_n_d = 1'b1;
    end else if (tick) begin
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == CNT_MAX) to_n_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      rr_q   <= '0;
      to_n_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_d;
      rr_q   <= rr_d;
      to_n_q <= to_n_d;
    end
  end

  assign count      = cnt_q;
  assign reload_val = rr_q;
  assign timeout_n  = to_n_q;
endmodule

// File: rtl/tick_timer_cluster.sv
module tick_timer_cluster
  import tick_timer_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int B_DIV       = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slow_clk,
  input  logic             console_hold,
  input  logic             ext_mode,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             tma_load,
  input  logic             tma_start,
  input  logic             tma_halt,
  input  logic             tma_rr_wr,
  input  logic             tmb_load,
  input  logic             tmb_start,
  input  logic             tmb_halt,
  input  logic             tmb_rr_wr,
  input  logic             wd_rr_wr,
  input  logic             wd_go,
  output logic [CNT_W-1:0] tma_count,
  output logic [CNT_W-1:0] tmb_count,
  output logic [CNT_W-1:0] wd_count,
  output logic             tma_irq,
  output logic             tmb_irq,
  output logic             wd_timeout_n
);
  localparam int NUM_TMR = 2;

  logic [1:0]       rst_pipe_q;
  logic             rst_sync_n;
  logic             rise_tick, fall_tick, b_tick;
  tmr_cmd_t         cmd_v   [NUM_TMR];
  logic [CNT_W-1:0] count_v [NUM_TMR];
  logic             tick_v    [NUM_TMR];
  logic             ovf_v     [NUM_TMR];
  logic             loaded_v  [NUM_TMR];
  logic             running_v [NUM_TMR];
  logic [CNT_W-1:0] wd_rr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  slow_clk_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .async_in (slow_clk),
    .rise_tick(rise_tick),
    .fall_tick(fall_tick)
  );

  tick_prescaler #(.DIV(B_DIV)) u_presc (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .clear(tmb_load),
    .step (rise_tick && running_v[1] && !console_hold),
    .carry(b_tick)
  );

  assign cmd_v[0] = '{load: tma_load, start: tma_start, halt: tma_halt, rr_wr: tma_rr_wr};
  assign cmd_v[1] = '{load: tmb_load, start: tmb_start, halt: tmb_halt, rr_wr: tmb_rr_wr};

  generate
    for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
      assign tick_v[i] = (i == 0) ? rise_tick : b_tick;
      interval_counter #(.W(CNT_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_sync_n),
        .tick     (tick_v[i]),
        .hold     (console_hold),
        .ext_mode (ext_mode),
        .cmd      (cmd_v[i]),
        .wr_data  (wr_data),
        .count    (count_v[i]),
        .ovf_pulse(ovf_v[i]),
        .loaded   (loaded_v[i]),
        .running  (running_v[i])
      );
    end
  endgenerate

  watchdog_counter #(.W(CNT_W)) u_wd (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .tick      (fall_tick),
    .go        (wd_go),
    .rr_wr     (wd_rr_wr),
    .wr_data   (wr_data),
    .count     (wd_count),
    .reload_val(wd_rr_q),
    .timeout_n (wd_timeout_n)
  );

  assign tma_count = count_v[0];
  assign tmb_count = count_v[1];
  assign tma_irq   = ovf_v[0];
  assign tmb_irq   = ovf_v[1];
endmodule

// File: rtl/tick_timer_checker.sv
module tick_timer_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             console_hold,
  input logic             ext_mode,
  input logic [CNT_W-1:0] wr_data,
  input logic             tma_load,
  input logic             tma_halt,
  input logic             tmb_load,
  input logic [CNT_W-1:0] tma_count,
  input logic [CNT_W-1:0] tmb_count,
  input logic             tma_irq,
  input logic             tmb_irq,
  input logic             loaded_a,
  input logic             run_a,
  input logic             fall_tick,
  input logic             wd_go,
  input logic [CNT_W-1:0] wd_count,
  input logic [CNT_W-1:0] wd_rr,
  input logic             wd_timeout_n
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    tma_load |=> tma_count == $past(wr_data)); // R4

  AST_HALT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    tma_halt |=> !run_a); // R5

  AST_HOLD_FREEZE_A: assert property (@(posedge clk) disable iff (!rst_n)
    (console_hold && !tma_load) |=> tma_count == $past(tma_count)); // R6

  AST_HOLD_FREEZE_B: assert property (@(posedge clk) disable iff (!rst_n)
    (console_hold && !tmb_load) |=> tmb_count == $past(tmb_count)); // R6

  AST_IRQ_A_AFTER_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tma_irq) |-> $past(tma_count) == CNT_MAX); // R7

  AST_IRQ_A_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    tma_irq |=> !tma_irq); // R7

  AST_IRQ_B_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    tmb_irq |=> !tmb_irq); // R7

  AST_WRAP_ZERO_A: assert property (@(posedge clk) disable iff (!rst_n)
    (tma_irq && !($past(ext_mode) && $past(loaded_a))) |-> tma_count == '0); // R8

  AST_WD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!wd_go && !fall_tick) |=> wd_count == $past(wd_count)); // R9

  AST_WD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!wd_timeout_n && !wd_go) |=> !wd_timeout_n); // R10

  AST_WD_GO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wd_go |=> (wd_timeout_n && wd_count == $past(wd_rr))); // R10
endmodule

bind tick_timer_cluster tick_timer_checker #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .console_hold(console_hold),
  .ext_mode    (ext_mode),
  .wr_data     (wr_data),
  .tma_load    (tma_load),
  .tma_halt    (tma_halt),
  .tmb_load    (tmb_load),
  .tma_count   (tma_count),
  .tmb_count   (tmb_count),
  .tma_irq     (tma_irq),
  .tmb_irq     (tmb_irq),
  .loaded_a    (loaded_v[0]),
  .run_a       (running_v[0]),
  .fall_tick   (fall_tick),
  .wd_go       (wd_go),
  .wd_count    (wd_count),
  .wd_rr       (wd_rr_q),
  .wd_timeout_n(wd_timeout_n)
);

// File: tb/tick_timer_cluster_bench.sv
module tick_timer_cluster_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slow_clk = 1'b0;
  logic        console_hold = 1'b0;
  logic        ext_mode = 1'b0;
  logic [15:0] wr_data = '0;
  logic        tma_load = 0, tma_start = 0, tma_halt = 0, tma_rr_wr = 0;
  logic        tmb_load = 0, tmb_start = 0, tmb_halt = 0, tmb_rr_wr = 0;
  logic        wd_rr_wr = 0, wd_go = 0;
  logic [15:0] tma_count, tmb_count, wd_count;
  logic        tma_irq, tmb_irq, wd_timeout_n;

  always #5 clk = ~clk;

  tick_timer_cluster u_tick_timer_cluster (.*);

  int checks = 0, fails = 0, irq_a_seen = 0, irq_b_seen = 0, cycles = 0;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (rst_n && tma_irq) irq_a_seen <= irq_a_seen + 1;
    if (rst_n && tmb_irq) irq_b_seen <= irq_b_seen + 1;
  end

  // model state
  logic [15:0] m_a, m_b, m_rra, m_rrb, m_wd, m_wdrr;
  logic        m_lda, m_ldb, m_runa, m_runb, m_to_n;
  int          m_pre, m_irqa, m_irqb;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ovf_value(input logic ext, input logic ld,
                                             input logic [15:0] rr);
    return (ext && ld) ? rr : 16'h0000;
  endfunction

  task automatic model_reset();
    m_a = 0; m_b = 0; m_rra = 0; m_rrb = 0; m_wd = 0; m_wdrr = 0;
    m_lda = 0; m_ldb = 0; m_runa = 1; m_runb = 1; m_to_n = 1;
    m_pre = 0; m_irqa = 0; m_irqb = 0;
  endtask

  task automatic model_rise();
    if (m_runa && !console_hold) begin
      if (m_a == 16'hFFFF) begin m_a = ovf_value(ext_mode, m_lda, m_rra); m_irqa++; end
      else m_a = m_a + 1;
    end
    if (m_runb && !console_hold) begin
      m_pre++;
      if (m_pre == 10) begin
        m_pre = 0;
        if (m_b == 16'hFFFF) begin m_b = ovf_value(ext_mode, m_ldb, m_rrb); m_irqb++; end
        else m_b = m_b + 1;
      end
    end
  endtask

  task automatic model_fall();
    if (m_wd == 16'hFFFF) m_to_n = 0;
    m_wd = m_wd + 1;
  endtask

  task automatic compare_all(input string req);
    chk({req, " tma_count"}, tma_count, m_a);
    chk({req, " tmb_count"}, tmb_count, m_b);
    chk({req, " wd_count"}, wd_count, m_wd);
    chk({req, " wd_timeout_n"}, wd_timeout_n, m_to_n);
    chk({req, " irq A count"}, irq_a_seen, m_irqa);
    chk({req, " irq B count"}, irq_b_seen, m_irqb);
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic slow_cycle();
    slow_clk = 1'b1; wait_n(5); model_rise();
    slow_clk = 1'b0; wait_n(5); model_fall();
  endtask

  task automatic pulse(ref logic sig, input logic [15:0] d);
    wr_data = d; sig = 1'b1; wait_n(1); sig = 1'b0; wait_n(1);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wait_n(3); rst_n = 1'b1; wait_n(4);
    irq_a_seen = 0; irq_b_seen = 0;
    model_reset();
  endtask

  function automatic logic [15:0] near_max();
    return ($urandom_range(0, 1) == 1) ? (16'hFFF0 | 16'($urandom_range(0, 15)))
                                       : 16'($urandom());
  endfunction

  initial begin
    int seed_dummy;
    logic [15:0] v;
    seed_dummy = $urandom(32'h5EED);
    do_reset();
    // R1 reset state
    chk("R1 tma_count", tma_count, 0);
    chk("R1 tmb_count", tmb_count, 0);
    chk("R1 wd_count", wd_count, 0);
    chk("R1 wd_timeout_n", wd_timeout_n, 1);
    chk("R1 irq", {tma_irq, tmb_irq}, 0);
    // R2/R9 single slow cycle
    slow_cycle();
    chk("R2 tma one tick", tma_count, 1);
    chk("R9 wd one tick", wd_count, 1);
    // R3 prescaler restart on load of B
    pulse(tmb_load, 16'h0100); m_b = 16'h0100; m_ldb = 1; m_pre = 0;
    for (int i = 0; i < 9; i++) slow_cycle();
    chk("R3 tmb before tenth", tmb_count, 16'h0100);
    slow_cycle();
    chk("R3 tmb at tenth", tmb_count, 16'h0101);
    // R11 reload writes leave counts
    pulse(tma_rr_wr, 16'hABCD); m_rra = 16'hABCD;
    pulse(wd_rr_wr, 16'h1111); m_wdrr = 16'h1111;
    compare_all("R11");
    // R5 start and halt together -> halted
    tma_start = 1; tma_halt = 1; wait_n(1); tma_start = 0; tma_halt = 0; wait_n(1);
    m_runa = 0;
    slow_cycle();
    compare_all("R5 halt wins");
    pulse(tma_start, 16'h0); m_runa = 1;
    // R8 ext overflow from loaded timer A
    ext_mode = 1;
    pulse(tma_load, 16'hFFFF); m_a = 16'hFFFF; m_lda = 1;
    slow_cycle();
    compare_all("R8 R7 reload");
    chk("R8 reload value", tma_count, 16'hABCD);

    // random phase
    for (int it = 0; it < 400; it++) begin
      int act;
      string tag;
      act = $urandom_range(0, 11);
      case (act)
        0, 1, 2, 3, 4: begin slow_cycle(); tag = "R2 R3 R7 R8 R9 step"; end
        5: begin v = near_max(); pulse(tma_load, v); m_a = v; m_lda = 1; tag = "R4 load A"; end
        6: begin v = near_max(); pulse(tmb_load, v); m_b = v; m_ldb = 1; m_pre = 0; tag = "R4 load B"; end
        7: begin
          if ($urandom_range(0, 1) == 1) begin
            if ($urandom_range(0, 1) == 1) begin pulse(tma_halt, 0); m_runa = 0; end
            else begin pulse(tma_start, 0); m_runa = 1; end
          end else begin
            if ($urandom_range(0, 1) == 1) begin pulse(tmb_halt, 0); m_runb = 0; end
            else begin pulse(tmb_start, 0); m_runb = 1; end
          end
          tag = "R5 start halt";
        end
        8: begin
          v = 16'($urandom());
          if ($urandom_range(0, 1) == 1) begin pulse(tma_rr_wr, v); m_rra = v; end
          else begin pulse(tmb_rr_wr, v); m_rrb = v; end
          tag = "R11 reload write";
        end
        9: begin v = near_max(); pulse(wd_rr_wr, v); m_wdrr = v; tag = "R11 wd reload write"; end
        10: begin pulse(wd_go, 0); m_wd = m_wdrr; m_to_n = 1; tag = "R10 go"; end
        default: begin
          if ($urandom_range(0, 1) == 1) console_hold = ~console_hold;
          else ext_mode = ~ext_mode;
          wait_n(1);
          tag = "R6 R8 mode change";
        end
      endcase
      compare_all(tag);
    end
    console_hold = 0;

    // long run: never-loaded overflow and full watchdog period
    do_reset();
    ext_mode = 1;
    pulse(tma_rr_wr, 16'h1234);
    for (int i = 0; i < 65535; i++) begin
      slow_clk = 1'b1; wait_n(1); slow_clk = 1'b0; wait_n(1);
    end
    wait_n(6);
    chk("R2 tma at max", tma_count, 16'hFFFF);
    chk("R3 tmb after 65535 edges", tmb_count, 16'd6553);
    chk("R10 no timeout before 65536", wd_timeout_n, 1);
    chk("R9 wd at max", wd_count, 16'hFFFF);
    slow_clk = 1'b1; wait_n(1); slow_clk = 1'b0; wait_n(6);
    chk("R8 unloaded wraps to zero", tma_count, 0);
    chk("R7 irq A once", irq_a_seen, 1);
    chk("R10 timeout at 65536", wd_timeout_n, 0);
    chk("R10 wd wrapped", wd_count, 0);
    wait_n(5);
    chk("R10 timeout sticky", wd_timeout_n, 0);
    pulse(wd_rr_wr, 16'h4321);
    pulse(wd_go, 0);
    chk("R10 go clears", wd_timeout_n, 1);
    chk("R10 go reloads", wd_count, 16'h4321);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    wait (cycles >= 190000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=<190000", cycles);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule